// File: doc/BRIEF.md
# Address Range Watchpoint Comparator Unit

This unit sits beside a processor's data access bus and raises a debug event when an access lands on a programmed address window. It holds two address value registers, called E and F, each paired with a relational test and an access-direction qualifier. A combination selector then merges the two comparator results into a single watchpoint. Debug software programs the unit through a small register write port.

A typical setup watches an arbitrary byte range [A, A+L). E is loaded with A-1 and uses a greater-than test. F is loaded with A+L and uses a less-than test. The watchpoint then requires both comparators to match. If the range begins at address zero, only F is used. If the range ends at the top of the address space, so that A+L wraps to zero, only E is used. Every comparison is unsigned. Only the starting address of an access is examined.

On a hit the unit produces a single-cycle pulse, sets a sticky flag and records the address of the access. The flag stays set until software clears it with a write-one.

Top module: `addr_watch_unit`

## Requirements
- R1: Each comparator takes its test code from control word 1, bits 31:29 for E and bits 28:26 for F. Code 100 matches on equal, 110 when the access address is greater than the value, and 101 when it is less than the value. All tests are unsigned. Any other code never matches.
- R2: Each comparator takes its direction qualifier from control word 1, bits 19:18 for E and bits 17:16 for F. Code 00 accepts reads and writes, 01 accepts reads only (acc_write=0), 11 accepts writes only (acc_write=1), and 10 accepts nothing. A rejected access produces no comparator match.
- R3: Control word 2 bits 27:26 select the combination. 00 uses E alone, 01 uses F alone, 10 requires both E and F, and 11 never fires.
- R4: The watchpoint fires only when control word 2 bits 31, 25 and 1 are all set. Writing zero to control word 2 silences the unit completely while the comparators are reprogrammed.
- R5: Programming E=A-1 with greater-than, F=A+L with less-than and combination 10 flags exactly the addresses A through A+L-1. F alone covers a range that starts at 0. E alone covers a range that ends at 0xFFFFFFFF.
- R6: hit_pulse is high for exactly the one cycle after a clock edge that samples acc_valid=1 with a qualifying access, and at no other time.
- R7: On every hit, hit_sticky is set and hit_addr takes the address of that access.
- R8: A write with wr_sel=4 and wr_data bit 0 set clears hit_sticky. If a hit occurs in the same cycle, the hit wins. A status write with bit 0 clear has no effect.
- R9: Register writes use wr_sel 0 (E value), 1 (F value), 2 (control 1) and 3 (control 2). A write takes effect at the clock edge that samples it, so an access in the same cycle is judged against the old settings. Writes with wr_sel 5 to 7 change nothing.
- R10: Synchronous reset clears every register, so after reset hit_pulse, hit_sticky and hit_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 E value, 1 F value, 2 control 1, 3 control 2, 4 status |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | ADDR_W | Starting byte address of the access |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| hit_pulse | output | 1 | One-cycle watchpoint hit |
| hit_sticky | output | 1 | Sticky hit flag, cleared by a write-one |
| hit_addr | output | ADDR_W | Address of the most recent hit |

## Verification
A wrong value in a comparator value register or control field shows up as a hit_pulse that is missing or extra. The error appears one cycle after the first access whose address lies on the wrong side of an affected boundary, so the stimulus concentrates on A-1, A, A+L-1 and A+L, and on the wrap cases at 0 and 0xFFFFFFFF. A corrupted sticky flag or capture register shows on hit_sticky or hit_addr immediately after the next hit or clear, and both outputs are compared on every cycle against a reference model.

// File: rtl/awu_pkg.sv
package awu_pkg;

   localparam int CTRL_W = 32;

   // relational test codes
   localparam logic [2:0] TST_EQ = 3'b100;
   localparam logic [2:0] TST_GT = 3'b110;
   localparam logic [2:0] TST_LT = 3'b101;

   // direction qualifier codes
   localparam logic [1:0] QL_ANY = 2'b00;
   localparam logic [1:0] QL_RD  = 2'b01;
   localparam logic [1:0] QL_WR  = 2'b11;

   // combination codes
   localparam logic [1:0] CMB_E   = 2'b00;
   localparam logic [1:0] CMB_F   = 2'b01;
   localparam logic [1:0] CMB_EF  = 2'b10;

   // write-port selects
   typedef enum logic [2:0] {
      SEL_VAL_E = 3'd0,
      SEL_VAL_F = 3'd1,
      SEL_CTL1  = 3'd2,
      SEL_CTL2  = 3'd3,
      SEL_STAT  = 3'd4
   } wsel_e;

   // per-comparator settings
   typedef struct packed {
      logic [2:0] test;
      logic [1:0] qual;
   } cmp_cfg_t;

   // watchpoint settings
   typedef struct packed {
      logic       en;
      logic       care;
      logic       sec;
      logic [1:0] comb;
   } wp_cfg_t;

endpackage

// File: rtl/awu_regs.sv
module awu_regs
   import awu_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_CMP = 2
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [2:0]              wr_sel,
   input  logic [CTRL_W-1:0]       wr_data,
   output logic [ADDR_W-1:0]       cmp_val [NUM_CMP],
   output cmp_cfg_t                cmp_cfg [NUM_CMP],
   output wp_cfg_t                 wp_cfg
);

   // bits of a control write that no field consumes
   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[25:20], wr_data[15:0], wr_data[30:28], wr_data[24:2], wr_data[0]};

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_reg
         localparam int TST_HI = 31 - 3 * i;
         localparam int QL_HI  = 19 - 2 * i;
         always_ff @(posedge clk) begin
            if (rst) begin
               cmp_val[i] <= '0;
               cmp_cfg[i] <= '0;
            end else if (wr_en) begin
               if (wr_sel == 3'(i))
                  cmp_val[i] <= wr_data[ADDR_W-1:0];
               if (wr_sel == SEL_CTL1) begin
                  cmp_cfg[i].test <= wr_data[TST_HI -: 3];
                  cmp_cfg[i].qual <= wr_data[QL_HI -: 2];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_cfg <= '0;
      end else if (wr_en && wr_sel == SEL_CTL2) begin
         wp_cfg.en   <= wr_data[31];
         wp_cfg.comb <= wr_data[27:26];
         wp_cfg.care <= wr_data[25];
         wp_cfg.sec  <= wr_data[1];
      end
   end

endmodule

// File: rtl/awu_cmp.sv
module awu_cmp
   import awu_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic [ADDR_W-1:0] value,
   input  cmp_cfg_t          cfg,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              match
);

   logic rel_ok;
   logic dir_ok;

   always_comb begin
      unique case (cfg.test)
         TST_EQ:  rel_ok = (acc_addr == value);
         TST_GT:  rel_ok = (acc_addr >  value);
         TST_LT:  rel_ok = (acc_addr <  value);
         default: rel_ok = 1'b0;
      endcase
   end

   always_comb begin
      unique case (cfg.qual)
         QL_ANY:  dir_ok = 1'b1;
         QL_RD:   dir_ok = !acc_write;
         QL_WR:   dir_ok = acc_write;
         default: dir_ok = 1'b0;
      endcase
   end

   assign match = rel_ok && dir_ok;

endmodule

// File: rtl/awu_hit.sv
module awu_hit
   import awu_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst,
   input  wp_cfg_t           wp_cfg,
   input  logic              match_e,
   input  logic              match_f,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              stat_clr,
   output logic              hit_pulse,
   output logic              hit_sticky,
   output logic [ADDR_W-1:0] hit_addr
);

   logic comb_ok;
   logic armed;
   logic fire;

   always_comb begin
      unique case (wp_cfg.comb)
         CMB_E:   comb_ok = match_e;
         CMB_F:   comb_ok = match_f;
         CMB_EF:  comb_ok = match_e && match_f;
         default: comb_ok = 1'b0;
      endcase
   end

   assign armed = wp_cfg.en && wp_cfg.care && wp_cfg.sec;
   assign fire  = acc_valid && armed && comb_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_pulse  <= 1'b0;
         hit_sticky <= 1'b0;
         hit_addr   <= '0;
      end else begin
         hit_pulse <= fire;
         if (fire) begin
            hit_sticky <= 1'b1;
            hit_addr   <= acc_addr;
         end else if (stat_clr) begin
            hit_sticky <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
   import awu_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              hit_pulse,
   output logic              hit_sticky,
   output logic [ADDR_W-1:0] hit_addr
);

   localparam int NUM_CMP = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > CTRL_W) begin : g_bad_width
         $error("addr_watch_unit: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic [ADDR_W-1:0] cmp_val [NUM_CMP];
   cmp_cfg_t          cmp_cfg [NUM_CMP];
   wp_cfg_t           wp_cfg;
   logic [NUM_CMP-1:0] cmp_match;
   logic              stat_clr;

   assign stat_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[0];

   awu_regs #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cmp_val (cmp_val),
      .cmp_cfg (cmp_cfg),
      .wp_cfg  (wp_cfg)
   );

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
         awu_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .value     (cmp_val[i]),
            .cfg       (cmp_cfg[i]),
            .acc_addr  (acc_addr),
            .acc_write (acc_write),
            .match     (cmp_match[i])
         );
      end
   endgenerate

   awu_hit #(.ADDR_W(ADDR_W)) u_hit (
      .clk        (clk),
      .rst        (rst),
      .wp_cfg     (wp_cfg),
      .match_e    (cmp_match[0]),
      .match_f    (cmp_match[1]),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .stat_clr   (stat_clr),
      .hit_pulse  (hit_pulse),
      .hit_sticky (hit_sticky),
      .hit_addr   (hit_addr)
   );

endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
   parameter int ADDR_W = 32
)(
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [31:0]       wr_data,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              hit_pulse,
   input logic              hit_sticky,
   input logic [ADDR_W-1:0] hit_addr
);

   AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |-> $past(acc_valid)); // R6

   AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |-> hit_sticky); // R7

   AST_PULSE_CAPTURES_ADDR: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |-> hit_addr == $past(acc_addr)); // R7

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (hit_sticky && !(wr_en && wr_sel == 3'd4 && wr_data[0])) |=> hit_sticky); // R8

   AST_STICKY_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
      $rose(hit_sticky) |-> hit_pulse); // R7

   AST_CTRL2_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en && wr_sel == 3'd3 && wr_data == 32'd0) && acc_valid) |=> !hit_pulse); // R4

   AST_ADDR_STABLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      !hit_pulse |-> $stable(hit_addr) || $past(rst)); // R7

endmodule

bind addr_watch_unit awu_checker #(.ADDR_W(ADDR_W)) u_awu_checker (.*);

// File: tb/tb_addr_watch_unit.sv
`timescale 1ns/1ps
module tb_addr_watch_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [2:0]  wr_sel;
   logic [31:0] wr_data;
   logic        acc_valid;
   logic [31:0] acc_addr;
   logic        acc_write;
   logic        hit_pulse;
   logic        hit_sticky;
   logic [31:0] hit_addr;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   addr_watch_unit dut (.*);

   // reference model state
   logic [31:0] m_e, m_f, m_c1, m_c2;
   logic        m_sticky;
   logic [31:0] m_addr;

   function automatic bit cmp_ok(logic [2:0] t, logic [1:0] q, logic [31:0] v,
                                 logic [31:0] a, logic w);
      bit r, d;
      r = (t == 3'b100) ? (a == v) : (t == 3'b110) ? (a > v) : (t == 3'b101) ? (a < v) : 1'b0;
      d = (q == 2'b00) ? 1'b1 : (q == 2'b01) ? !w : (q == 2'b11) ? w : 1'b0;
      return r && d;
   endfunction

   function automatic bit model_fire(logic [31:0] a, logic w);
      bit me, mf, c;
      me = cmp_ok(m_c1[31:29], m_c1[19:18], m_e, a, w);
      mf = cmp_ok(m_c1[28:26], m_c1[17:16], m_f, a, w);
      case (m_c2[27:26])
         2'b00: c = me;
         2'b01: c = mf;
         2'b10: c = me && mf;
         default: c = 1'b0;
      endcase
      return m_c2[31] && m_c2[25] && m_c2[1] && c;
   endfunction

   function automatic logic [31:0] mk_c1(logic [2:0] te, logic [2:0] tf, logic [1:0] qe, logic [1:0] qf);
      return {te, tf, 6'd0, qe, qf, 16'd0};
   endfunction

   function automatic logic [31:0] mk_c2(logic [1:0] cmb);
      return 32'h8000_0000 | (32'(cmb) << 26) | 32'h0200_0000 | 32'h2;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check after the edge. force_exp: -1 model, 0/1 literal.
   task automatic cyc(bit v, logic [31:0] a, bit w, bit we, logic [2:0] sel,
                      logic [31:0] d, int force_exp, string req);
      bit exp_hit;
      acc_valid = v; acc_addr = a; acc_write = w;
      wr_en = we; wr_sel = sel; wr_data = d;
      exp_hit = v && model_fire(a, w);
      if (force_exp >= 0) begin
         check(exp_hit == bit'(force_exp), {req, " model"}, 32'(exp_hit), 32'(force_exp));
         exp_hit = bit'(force_exp);
      end
      @(posedge clk);
      #1;
      if (we) begin
         case (sel)
            3'd0: m_e  = d;
            3'd1: m_f  = d;
            3'd2: m_c1 = d;
            3'd3: m_c2 = d;
            default: ;
         endcase
      end
      if (exp_hit) begin
         m_sticky = 1'b1; m_addr = a;
      end else if (we && sel == 3'd4 && d[0]) begin
         m_sticky = 1'b0;
      end
      check(hit_pulse == exp_hit, {req, " hit_pulse"}, 32'(hit_pulse), 32'(exp_hit));
      check(hit_sticky == m_sticky, {req, " hit_sticky"}, 32'(hit_sticky), 32'(m_sticky));
      check(hit_addr == m_addr, {req, " hit_addr"}, hit_addr, m_addr);
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] d, string req);
      cyc(1'b0, 32'h0, 1'b0, 1'b1, sel, d, -1, req);
   endtask

   task automatic acc(logic [31:0] a, bit w, int e, string req);
      cyc(1'b1, a, w, 1'b0, 3'd0, 32'h0, e, req);
   endtask

   task automatic set_range(logic [31:0] base, logic [31:0] len, logic [1:0] q);
      wr(3'd3, 32'h0, "R4");
      wr(3'd0, base - 32'd1, "R9");
      wr(3'd1, base + len, "R9");
      wr(3'd2, mk_c1(3'b110, 3'b101, q, q), "R9");
      if (base == 32'd0)            wr(3'd3, mk_c2(2'b01), "R5");
      else if (base + len == 32'd0) wr(3'd3, mk_c2(2'b00), "R5");
      else                          wr(3'd3, mk_c2(2'b10), "R5");
   endtask

   initial begin
      #150000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      m_e = 0; m_f = 0; m_c1 = 0; m_c2 = 0; m_sticky = 0; m_addr = 0;
      rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0;
      acc_valid = 0; acc_addr = 0; acc_write = 0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check(hit_pulse == 1'b0, "R10 hit_pulse", 32'(hit_pulse), 32'd0);
      check(hit_sticky == 1'b0, "R10 hit_sticky", 32'(hit_sticky), 32'd0);
      check(hit_addr == 32'd0, "R10 hit_addr", hit_addr, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      acc(32'h0, 1'b0, 0, "R10 no hit after reset");

      // R5: middle range [0x1000, 0x1010)
      set_range(32'h1000, 32'h10, 2'b00);
      acc(32'h0FFF, 1'b0, 0, "R5 below");
      acc(32'h1000, 1'b0, 1, "R5 first");
      acc(32'h100F, 1'b1, 1, "R5 last");
      acc(32'h1010, 1'b0, 0, "R5 past");
      // R5: range starting at 0
      set_range(32'h0, 32'h20, 2'b00);
      acc(32'h0, 1'b0, 1, "R5 zero start");
      acc(32'h1F, 1'b1, 1, "R5 zero end");
      acc(32'h20, 1'b0, 0, "R5 zero past");
      // R5: range ending at top
      set_range(32'hFFFF_FFF0, 32'h10, 2'b00);
      acc(32'hFFFF_FFFF, 1'b0, 1, "R5 top last");
      acc(32'hFFFF_FFF0, 1'b0, 1, "R5 top first");
      acc(32'hFFFF_FFEF, 1'b0, 0, "R5 top below");

      // R2: qualifiers
      set_range(32'h2000, 32'h8, 2'b01);
      acc(32'h2004, 1'b0, 1, "R2 read-only read");
      acc(32'h2004, 1'b1, 0, "R2 read-only write");
      set_range(32'h2000, 32'h8, 2'b11);
      acc(32'h2004, 1'b1, 1, "R2 write-only write");
      acc(32'h2004, 1'b0, 0, "R2 write-only read");
      set_range(32'h2000, 32'h8, 2'b10);
      acc(32'h2004, 1'b1, 0, "R2 reserved qual");

      // R1: equality and reserved test codes, unsigned compare
      wr(3'd0, 32'h8000_0000, "R1");
      wr(3'd2, mk_c1(3'b100, 3'b000, 2'b00, 2'b00), "R1");
      wr(3'd3, mk_c2(2'b00), "R1");
      acc(32'h8000_0000, 1'b0, 1, "R1 equal");
      acc(32'h8000_0001, 1'b0, 0, "R1 not equal");
      wr(3'd2, mk_c1(3'b110, 3'b000, 2'b00, 2'b00), "R1");
      acc(32'hF000_0000, 1'b0, 1, "R1 unsigned greater");
      acc(32'h0000_0001, 1'b0, 0, "R1 unsigned smaller");
      wr(3'd2, mk_c1(3'b111, 3'b000, 2'b00, 2'b00), "R1");
      acc(32'hF000_0000, 1'b0, 0, "R1 reserved test");

      // R3: combination 11 never fires; F-only ignores E
      wr(3'd2, mk_c1(3'b110, 3'b110, 2'b00, 2'b00), "R3");
      wr(3'd3, mk_c2(2'b11), "R3");
      acc(32'hF000_0000, 1'b0, 0, "R3 comb 11");
      wr(3'd1, 32'hFFFF_FFFF, "R3");
      wr(3'd3, mk_c2(2'b01), "R3");
      acc(32'hF000_0000, 1'b0, 0, "R3 F only");

      // R4: each arming bit required
      set_range(32'h3000, 32'h10, 2'b00);
      wr(3'd3, mk_c2(2'b10) & ~32'h0200_0000, "R4");
      acc(32'h3008, 1'b0, 0, "R4 care bit clear");
      wr(3'd3, mk_c2(2'b10) & ~32'h2, "R4");
      acc(32'h3008, 1'b0, 0, "R4 secondary clear");
      wr(3'd3, mk_c2(2'b10) & ~32'h8000_0000, "R4");
      acc(32'h3008, 1'b0, 0, "R4 enable clear");

      // R9: same-cycle write uses old settings; selects 5..7 ignored
      wr(3'd3, mk_c2(2'b10), "R9");
      cyc(1'b1, 32'h3008, 1'b0, 1'b1, 3'd3, 32'h0, 1, "R9 old settings");
      acc(32'h3008, 1'b0, 0, "R4 ctrl2 zero");
      wr(3'd3, mk_c2(2'b10), "R9");
      wr(3'd5, 32'h0, "R9");
      wr(3'd7, 32'h0, "R9");
      acc(32'h3008, 1'b0, 1, "R9 ignored selects");

      // R8: status clear
      wr(3'd4, 32'h0, "R8 write zero no effect");
      wr(3'd4, 32'h1, "R8 clear");
      cyc(1'b1, 32'h3004, 1'b0, 1'b1, 3'd4, 32'h1, 1, "R8 hit beats clear");
      wr(3'd4, 32'h1, "R8 clear again");
      // R6: invalid access never hits
      cyc(1'b0, 32'h3004, 1'b0, 1'b0, 3'd0, 32'h0, 0, "R6 no valid");

      // constrained random
      for (int r = 0; r < 60; r++) begin
         logic [31:0] b, l;
         b = $urandom;
         l = ($urandom % 64) + 1;
         case ($urandom % 4)
            0: b = 32'h0;
            1: b = 32'h0 - l;
            default: ;
         endcase
         set_range(b, l, 2'($urandom % 4));
         if ($urandom % 5 == 0)
            wr(3'd2, $urandom, "R1 random ctrl");
         for (int k = 0; k < 40; k++) begin
            logic [31:0] a;
            case ($urandom % 6)
               0: a = b - 1;
               1: a = b;
               2: a = b + l - 1;
               3: a = b + l;
               4: a = b + ($urandom % l);
               default: a = $urandom;
            endcase
            cyc(($urandom % 8) != 0, a, 1'($urandom), ($urandom % 16) == 0,
                3'd4, 32'h1, -1, "R6 random");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule